// File: doc/BRIEF.md
# Bounded Context Stack With Checkpoint

This block holds the mutable state of a byte-level pattern recogniser that pairs a bit-parallel automaton with a small nesting counter. It keeps a wide automaton state register, a fixed-depth last-in-first-out stack of short context tags, and one shadow copy of both. For every advanced byte the surrounding logic supplies the next automaton state, a stack action (none, push, pop, or replace-top), the tag to write, and a flag saying the byte was not a legal input. The block answers with a stack-empty flag, a combinational accept that is the automaton's own accept gated by an empty stack, and a sticky error flag.

A host loads a start state in bulk, saves it with a checkpoint, runs a candidate byte sequence, reads accept and error, and then restores the checkpoint to try the next candidate without reloading. Checkpoint and restore each take one clock. The low four bits of the automaton state are always visible for bring-up.

Top module: `ctx_stack_engine`

## Requirements
- R1: Hardware reset `rst` or command `cmd_reset` sets the stack pointer to 0, clears every stack entry, sets the automaton state to one-hot bit 0 (so `nfa_dbg` reads 4'b0001), clears `error`, and sets the checkpoint copy to this same state; results are visible after the next rising edge.
- R2: A step with `step_act` = 2'd1 (push) on a non-full stack writes `step_sym` at the slot above the top and increments `sp_out`; `top_entry` then shows `step_sym`. `sp_out` never exceeds DEPTH.
- R3: A push when `sp_out` equals DEPTH sets `error` and leaves `sp_out` and every stack entry unchanged.
- R4: A step with `step_act` = 2'd2 (pop) decrements `sp_out`; a pop on an empty stack sets `error` and leaves `sp_out` at 0.
- R5: A step with `step_act` = 2'd3 (replace-top) overwrites the top entry with `step_sym` and keeps `sp_out`; on an empty stack it sets `error` and changes nothing. `step_act` = 2'd0 leaves the stack alone.
- R6: `accept` equals `nfa_accept` AND (`sp_out` == 0) combinationally, with no clock between them.
- R7: A step with `invalid_byte` high sets `error`.
- R8: Once set, `error` stays set through steps, checkpoint and restore; only reset or load clears it.
- R9: `cmd_load` writes the automaton state from `load_nfa`, the stack image from `load_stack` (entry i in bits [4i+3:4i], entry 0 at the bottom) and the pointer from the byte `load_sp`, and clears `error`; a `load_sp` above DEPTH stores DEPTH and sets `error` instead.
- R10: `cmd_ckpt` copies automaton state, pointer and stack into the shadow in one cycle; `cmd_restore` copies them back in one cycle and may be repeated to replay the same start state.
- R11: Every step loads `nfa_next` into the automaton state; `nfa_dbg` always shows its low four bits.
- R12: When several commands arrive in one cycle, the order of precedence is reset, then load, then restore, then checkpoint, then step; only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reset | input | 1 | Reset command, same effect as rst |
| cmd_load | input | 1 | Bulk load of automaton state, pointer and stack |
| cmd_ckpt | input | 1 | Save state into the shadow copy |
| cmd_restore | input | 1 | Bring the shadow copy back |
| step_valid | input | 1 | Advance by one byte |
| step_act | input | 2 | Stack action: 0 none, 1 push, 2 pop, 3 replace-top |
| step_sym | input | EW | Tag pushed or written on top |
| nfa_next | input | NFA_W | Automaton state after this byte |
| invalid_byte | input | 1 | Current byte is not a legal input |
| nfa_accept | input | 1 | Accept of the automaton alone |
| load_nfa | input | NFA_W | Automaton state to load |
| load_sp | input | 8 | Stack pointer to load |
| load_stack | input | DEPTH*EW | Packed stack image to load |
| accept | output | 1 | nfa_accept gated by an empty stack |
| stack_empty | output | 1 | Stack pointer is zero |
| error | output | 1 | Sticky fault flag |
| sp_out | output | PTR_W | Current stack pointer |
| top_entry | output | EW | Top tag, zero when empty |
| nfa_dbg | output | 4 | Low four bits of the automaton state |

## Verification
The bench builds the block at its default sizes: sixteen entries of four bits and a 64-bit automaton state. With sixteen pushes it reaches the full boundary and the rejected seventeenth push, and the load path can be driven with an out-of-range pointer byte of 20 to reach the clamp. The full-width image lets each entry hold its own index, so the top tag after any load, pop or restore reveals exactly which slot the pointer selects.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2,
    ACT_SWAP = 2'd3
  } stack_act_e;
endpackage

// File: rtl/ctx_lifo.sv
module ctx_lifo
  import ctx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EW    = 4,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                do_reset,
  input  logic                do_load,
  input  logic                do_restore,
  input  logic                do_ckpt,
  input  logic                do_step,
  input  stack_act_e          act,
  input  logic [EW-1:0]       sym,
  input  logic [7:0]          ld_sp,
  input  logic [DEPTH*EW-1:0] ld_img,
  output logic [PTR_W-1:0]    sp_q,
  output logic [EW-1:0]       top,
  output logic                empty,
  output logic                step_fault,
  output logic                ld_over
);
  localparam logic [PTR_W-1:0] FULL_SP = PTR_W'(DEPTH);

  logic [DEPTH*EW-1:0] img_q, sh_img_q;
  logic [PTR_W-1:0]    sh_sp_q;
  logic                full, wr_en;
  logic [PTR_W-1:0]    wr_idx;

  assign empty = (sp_q == '0);
  assign full  = (sp_q == FULL_SP);
  assign step_fault = do_step &&
                      ((act == ACT_PUSH && full) ||
                       ((act == ACT_POP || act == ACT_SWAP) && empty));
  assign ld_over = do_load && (int'(ld_sp) > DEPTH);

  // Write slot: above top for push, top for replace.
  assign wr_en  = do_step && !step_fault && (act == ACT_PUSH || act == ACT_SWAP);
  assign wr_idx = (act == ACT_PUSH) ? sp_q : sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (do_reset) begin
      sp_q     <= '0;
      img_q    <= '0;
      sh_sp_q  <= '0;
      sh_img_q <= '0;
    end else if (do_load) begin
      sp_q  <= ld_over ? FULL_SP : ld_sp[PTR_W-1:0];
      img_q <= ld_img;
    end else if (do_restore) begin
      sp_q  <= sh_sp_q;
      img_q <= sh_img_q;
    end else if (do_ckpt) begin
      sh_sp_q  <= sp_q;
      sh_img_q <= img_q;
    end else if (do_step && !step_fault) begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_en && wr_idx == PTR_W'(i)) img_q[i*EW +: EW] <= sym;
      if (act == ACT_PUSH)     sp_q <= sp_q + 1'b1;
      else if (act == ACT_POP) sp_q <= sp_q - 1'b1;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!empty && sp_q - 1'b1 == PTR_W'(i)) top = img_q[i*EW +: EW];
  end

  p_sp_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sp_q <= FULL_SP);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (do_step && act == ACT_PUSH && full) |=> (sp_q == FULL_SP && $stable(img_q)));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (do_step && act == ACT_POP && empty) |=> (sp_q == '0));
  p_swap_keeps_sp_r5: assert property (@(posedge clk) disable iff (rst)
    (do_step && act == ACT_SWAP) |=> $stable(sp_q));
  p_load_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    (do_load && int'(ld_sp) > DEPTH) |=> (sp_q == FULL_SP));
endmodule

// File: rtl/ctx_nfa_reg.sv
module ctx_nfa_reg #(
  parameter int NFA_W     = 64,
  parameter int START_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_reset,
  input  logic             do_load,
  input  logic             do_restore,
  input  logic             do_ckpt,
  input  logic             do_step,
  input  logic [NFA_W-1:0] ld_nfa,
  input  logic [NFA_W-1:0] nxt,
  output logic [NFA_W-1:0] nfa_q
);
  localparam logic [NFA_W-1:0] START = NFA_W'(1) << START_BIT;

  logic [NFA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (do_reset) begin
      nfa_q <= START;
      sh_q  <= START;
    end else if (do_load)    nfa_q <= ld_nfa;
    else if (do_restore)     nfa_q <= sh_q;
    else if (do_ckpt)        sh_q  <= nfa_q;
    else if (do_step)        nfa_q <= nxt;
  end

  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    do_reset |=> ($onehot(nfa_q) && nfa_q[START_BIT]));
  p_step_nfa_r11: assert property (@(posedge clk) disable iff (rst)
    do_step |=> (nfa_q == $past(nxt)));
endmodule

// File: rtl/ctx_stack_engine.sv
module ctx_stack_engine
  import ctx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int EW    = 4,
  parameter int NFA_W = 64,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_reset,
  input  logic                cmd_load,
  input  logic                cmd_ckpt,
  input  logic                cmd_restore,
  input  logic                step_valid,
  input  logic [1:0]          step_act,
  input  logic [EW-1:0]       step_sym,
  input  logic [NFA_W-1:0]    nfa_next,
  input  logic                invalid_byte,
  input  logic                nfa_accept,
  input  logic [NFA_W-1:0]    load_nfa,
  input  logic [7:0]          load_sp,
  input  logic [DEPTH*EW-1:0] load_stack,
  output logic                accept,
  output logic                stack_empty,
  output logic                error,
  output logic [PTR_W-1:0]    sp_out,
  output logic [EW-1:0]       top_entry,
  output logic [3:0]          nfa_dbg
);
  logic do_reset, do_load, do_restore, do_ckpt, do_step;
  logic step_fault, ld_over, err_q;
  logic [NFA_W-1:0] nfa_q;
  stack_act_e act;

  // Precedence: reset, load, restore, checkpoint, step.
  assign do_reset   = rst | cmd_reset;
  assign do_load    = !do_reset && cmd_load;
  assign do_restore = !do_reset && !cmd_load && cmd_restore;
  assign do_ckpt    = !do_reset && !cmd_load && !cmd_restore && cmd_ckpt;
  assign do_step    = !do_reset && !cmd_load && !cmd_restore && !cmd_ckpt && step_valid;
  assign act        = stack_act_e'(step_act);

  ctx_lifo #(.DEPTH(DEPTH), .EW(EW), .PTR_W(PTR_W)) u_lifo (
    .clk(clk), .rst(rst), .do_reset(do_reset), .do_load(do_load),
    .do_restore(do_restore), .do_ckpt(do_ckpt), .do_step(do_step),
    .act(act), .sym(step_sym), .ld_sp(load_sp), .ld_img(load_stack),
    .sp_q(sp_out), .top(top_entry), .empty(stack_empty),
    .step_fault(step_fault), .ld_over(ld_over)
  );

  ctx_nfa_reg #(.NFA_W(NFA_W), .START_BIT(0)) u_nfa (
    .clk(clk), .rst(rst), .do_reset(do_reset), .do_load(do_load),
    .do_restore(do_restore), .do_ckpt(do_ckpt), .do_step(do_step),
    .ld_nfa(load_nfa), .nxt(nfa_next), .nfa_q(nfa_q)
  );

  always_ff @(posedge clk) begin
    if (do_reset)     err_q <= 1'b0;
    else if (do_load) err_q <= ld_over;
    else if (step_fault || (do_step && invalid_byte)) err_q <= 1'b1;
  end

  assign error   = err_q;
  assign accept  = nfa_accept & stack_empty;
  assign nfa_dbg = nfa_q[3:0];

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !cmd_reset && !cmd_load) |=> err_q);
  p_invalid_err_r7: assert property (@(posedge clk) disable iff (rst)
    (do_step && invalid_byte) |=> err_q);
  p_load_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (!do_reset && cmd_load && int'(load_sp) <= DEPTH) |=> (sp_out == $past(load_sp[PTR_W-1:0])));
endmodule

// File: tb/tb_ctx_stack_engine.sv
module tb_ctx_stack_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16, EW = 4, NFA_W = 64, PTR_W = 5;
  localparam logic [63:0] IMG = 64'hFEDC_BA98_7654_3210;

  logic clk = 0, rst = 1;
  logic cmd_reset = 0, cmd_load = 0, cmd_ckpt = 0, cmd_restore = 0;
  logic step_valid = 0, invalid_byte = 0, nfa_accept = 0;
  logic [1:0] step_act = 0;
  logic [EW-1:0] step_sym = 0;
  logic [NFA_W-1:0] nfa_next = 64'h1, load_nfa = 0;
  logic [7:0] load_sp = 0;
  logic [DEPTH*EW-1:0] load_stack = 0;
  logic accept, stack_empty, error;
  logic [PTR_W-1:0] sp_out;
  logic [EW-1:0] top_entry;
  logic [3:0] nfa_dbg;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_stack_engine dut (.*);

  task automatic check(string req, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmd_reset = 0; cmd_load = 0; cmd_ckpt = 0; cmd_restore = 0;
    step_valid = 0; invalid_byte = 0;
  endtask

  task automatic do_step(logic [1:0] a, logic [3:0] s, logic inv);
    step_valid = 1; step_act = a; step_sym = s; invalid_byte = inv; tick();
  endtask

  task automatic do_reset();  cmd_reset = 1; tick(); nfa_next = 64'h1; endtask
  task automatic do_ckpt();   cmd_ckpt = 1; tick(); endtask
  task automatic do_restore(); cmd_restore = 1; tick(); endtask
  task automatic do_load(logic [63:0] n, logic [7:0] sp, logic [63:0] img);
    cmd_load = 1; load_nfa = n; load_sp = sp; load_stack = img; tick();
  endtask

  task automatic t_reset();
    check("R1 sp", sp_out, 0);
    check("R1 empty", stack_empty, 1);
    check("R1 err", error, 0);
    check("R1 dbg", nfa_dbg, 4'b0001);
    check("R1 top", top_entry, 0);
    nfa_accept = 1; #1;
    check("R6 accept empty", accept, 1);
    nfa_accept = 0; #1;
    check("R6 accept nfa low", accept, 0);
  endtask

  task automatic t_push_pop();
    do_step(2'd1, 4'h5, 0); do_step(2'd1, 4'h9, 0); do_step(2'd1, 4'hC, 0);
    check("R2 sp", sp_out, 3);
    check("R2 top", top_entry, 4'hC);
    nfa_accept = 1; #1;
    check("R6 accept nonempty", accept, 0);
    nfa_accept = 0;
    do_step(2'd2, 0, 0);
    check("R4 pop sp", sp_out, 2);
    check("R4 pop top", top_entry, 4'h9);
    do_step(2'd0, 4'h3, 0);
    check("R5 none keeps top", top_entry, 4'h9);
    do_step(2'd2, 0, 0); do_step(2'd2, 0, 0);
    check("R4 empty no err", error, 0);
    do_step(2'd2, 0, 0);
    check("R4 underflow err", error, 1);
    check("R4 underflow sp", sp_out, 0);
  endtask

  task automatic t_sticky();
    do_ckpt(); do_restore(); do_step(2'd1, 4'h7, 0);
    check("R8 sticky", error, 1);
    do_reset();
    check("R1 reset clears err", error, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) do_step(2'd1, 4'(i), 0);
    check("R2 full sp", sp_out, DEPTH);
    check("R2 full top", top_entry, 4'hF);
    check("R3 no err yet", error, 0);
    do_step(2'd1, 4'h3, 0);
    check("R3 overflow err", error, 1);
    check("R3 overflow sp", sp_out, DEPTH);
    check("R3 overflow top", top_entry, 4'hF);
    do_step(2'd2, 0, 0);
    check("R3 entry below intact", top_entry, 4'hE);
  endtask

  task automatic t_swap();
    do_reset();
    do_step(2'd1, 4'h4, 0);
    do_step(2'd3, 4'hA, 0);
    check("R5 swap sp", sp_out, 1);
    check("R5 swap top", top_entry, 4'hA);
    check("R5 swap no err", error, 0);
    do_step(2'd2, 0, 0);
    do_step(2'd3, 4'hB, 0);
    check("R5 swap empty err", error, 1);
    check("R5 swap empty sp", sp_out, 0);
  endtask

  task automatic t_invalid();
    do_reset();
    do_step(2'd0, 0, 1);
    check("R7 invalid err", error, 1);
    check("R7 sp", sp_out, 0);
  endtask

  task automatic t_load();
    do_load(64'h5, 8'd3, IMG);
    check("R9 err cleared", error, 0);
    check("R9 sp", sp_out, 3);
    check("R9 top", top_entry, 4'h2);
    check("R9 dbg", nfa_dbg, 4'h5);
    do_step(2'd2, 0, 0); do_step(2'd2, 0, 0);
    check("R9 bottom entry", top_entry, 4'h0);
    do_load(64'h5, 8'd20, IMG);
    check("R9 clamp sp", sp_out, DEPTH);
    check("R9 clamp top", top_entry, 4'hF);
    check("R9 clamp err", error, 1);
  endtask

  task automatic t_nfa();
    do_reset();
    nfa_next = 64'hABCD;
    do_step(2'd0, 0, 0);
    check("R11 dbg", nfa_dbg, 4'hD);
    nfa_next = 64'h2;
    do_step(2'd0, 0, 0);
    check("R11 dbg2", nfa_dbg, 4'h2);
  endtask

  task automatic t_ckpt();
    do_reset();
    do_restore();
    check("R10 shadow reset sp", sp_out, 0);
    check("R10 shadow reset dbg", nfa_dbg, 4'h1);
    do_load(64'h6, 8'd5, IMG);
    do_ckpt();
    nfa_next = 64'hA;
    do_step(2'd1, 4'h1, 0); do_step(2'd1, 4'h2, 0);
    check("R10 moved", sp_out, 7);
    do_restore();
    check("R10 restore sp", sp_out, 5);
    check("R10 restore top", top_entry, 4'h4);
    check("R10 restore dbg", nfa_dbg, 4'h6);
    do_step(2'd3, 4'h9, 0); do_step(2'd2, 0, 0); do_step(2'd2, 0, 0);
    do_restore();
    check("R10 replay sp", sp_out, 5);
    check("R10 replay top", top_entry, 4'h4);
  endtask

  task automatic t_prio();
    do_reset();
    cmd_load = 1; load_nfa = 64'h3; load_sp = 8'd2; load_stack = IMG;
    step_valid = 1; step_act = 2'd1; step_sym = 4'h8;
    tick();
    check("R12 load over step sp", sp_out, 2);
    check("R12 load over step top", top_entry, 4'h1);
    do_ckpt();
    cmd_reset = 1; cmd_load = 1; load_sp = 8'd4;
    tick();
    check("R12 reset over load", sp_out, 0);
    cmd_restore = 1; cmd_ckpt = 1;
    tick();
    check("R12 restore over ckpt", sp_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_push_pop(); t_sticky(); t_overflow(); t_swap();
    t_invalid(); t_load(); t_nfa(); t_ckpt(); t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule